// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that sits in memory. A requester presents a virtual address and an access kind (load, store or instruction fetch). The walker captures them together with the current table base. It then reads one directory word, and after that one leaf word, through a memory read port that has at most one read outstanding. It returns the physical address, the page's flag bits and a status code. The response stays presented until the requester acknowledges it.

Pages are 4 KB. The virtual address splits into three fields:
- bits 31:22 select the directory word;
- bits 21:12 select the leaf word in the second-level table;
- bits 11:0 pass straight through as the offset.

Every table word is 32 bits wide, so each index is multiplied by four to form a byte address. In every table word:
- bits 31:12 hold a frame number;
- bit 4 is dirty;
- bit 3 is execute;
- bit 2 is write;
- bit 1 is read;
- bit 0 is valid.

In a directory word, the frame field gives the base of the second-level table and only the valid bit is examined. In a leaf word, the frame field is the physical page and all the flags apply.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: A request is taken only while `req_ready_o` is 1, which holds only while no walk or response is pending. `req_valid_i` and the request fields presented during a walk have no effect on that walk or on its response.
- R3: The first read goes to the base captured at acceptance plus four times virtual address bits 31:22.
- R4: The second read goes to the directory word's bits 31:12 followed by twelve zero bits, plus four times virtual address bits 21:12.
- R5: On success `rsp_status_o` is 0 (ok). `rsp_paddr_o` is the leaf word's bits 31:12 joined with virtual address bits 11:0. `rsp_perm_o` is leaf bits 4:1, that is {dirty, execute, write, read}.
- R6: A directory word with bit 0 clear ends the walk after exactly one read, with `rsp_status_o` = 1 (page fault).
- R7: A leaf word with bit 0 clear gives `rsp_status_o` = 1 (page fault) after two reads.
- R8: For a valid leaf, the access kind sets the flag that is needed:
  - kind 0 (load) needs bit 1;
  - kind 1 (store) needs bit 2;
  - kind 2 (fetch) needs bit 3;
  - kind 3 is always refused.
  A refused access gives `rsp_status_o` = 2 (protection fault). Status 3 never occurs.
- R9: While `rsp_valid_o` is 1 and `rsp_ack_i` is 0, the response holds unchanged. An acknowledge returns the block to ready on the next cycle.
- R10: `mem_req_o` and `mem_addr_o` hold steady until `mem_rvalid_i` is seen. No read is pending while a response is presented. `mem_rvalid_i` has no effect while `mem_req_o` is 0.
- R11: On any fault, `rsp_paddr_o` and `rsp_perm_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | 32 | Byte address of the directory, captured when a request is accepted |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Response present |
| rsp_ack_i | input | 1 | Requester takes the response |
| rsp_status_o | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_perm_o | output | 4 | Leaf flags {dirty, execute, write, read} |
| mem_req_o | output | 1 | Table word read pending |
| mem_addr_o | output | 32 | Byte address of the table word |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Table word |

## Verification
The checker watches the handshake rules on every cycle:
- readiness only while nothing is pending;
- a stable response until it is acknowledged, and a return to ready after the acknowledge;
- a stable read request until its data arrives;
- no read overlapping a response;
- zeroed fields on faults and no illegal status code.

Only the bench scenarios can show that the correct table words were addressed and that the translation and fault decisions match the table contents. To do so, the bench compares each read address, the read count per walk and each response against a model of the tables. Those scenarios include extreme indices, a table base that changes, traffic presented during a walk and stray read data.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_L1 = 2'd1,
        ST_FETCH_L2 = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_e;

    // access kinds
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    // response codes
    localparam logic [1:0] RSP_OK         = 2'd0;
    localparam logic [1:0] RSP_PAGE_FAULT = 2'd1;
    localparam logic [1:0] RSP_PROT_FAULT = 2'd2;

    // flag positions inside a table word
    localparam int unsigned FLG_VALID = 0;
    localparam int unsigned FLG_READ  = 1;
    localparam int unsigned FLG_WRITE = 2;
    localparam int unsigned FLG_EXEC  = 3;
    localparam int unsigned FLG_DIRTY = 4;
    localparam int unsigned FLG_W     = FLG_DIRTY - FLG_READ + 1;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned WORD_LOG2 = 2
) (
    input  logic                    use_frame_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [ADDR_W-OFF_W-1:0] frame_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [ADDR_W-1:0]       addr_o
);
    localparam int unsigned PAD_W = ADDR_W - IDX_W - WORD_LOG2;

    logic [ADDR_W-1:0] root;
    logic [ADDR_W-1:0] step;

    always_comb begin
        root   = use_frame_i ? {frame_i, {OFF_W{1'b0}}} : base_i;
        step   = {{PAD_W{1'b0}}, idx_i, {WORD_LOG2{1'b0}}};
        addr_o = root + step;
    end
endmodule

// File: rtl/pgw_perm_check.sv
module pgw_perm_check
    import pgw_pkg::*;
(
    input  logic [FLG_W-1:0] flags_i,   // {dirty, exec, write, read}
    input  logic [1:0]       kind_i,
    output logic             allow_o
);
    always_comb begin
        unique case (kind_i)
            ACC_LOAD:  allow_o = flags_i[FLG_READ  - FLG_READ];
            ACC_STORE: allow_o = flags_i[FLG_WRITE - FLG_READ];
            ACC_FETCH: allow_o = flags_i[FLG_EXEC  - FLG_READ];
            default:   allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned WORD_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       tbl_base_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [31:0]       req_vaddr_i,
    input  logic [1:0]        req_kind_i,
    output logic              rsp_valid_o,
    input  logic              rsp_ack_i,
    output logic [1:0]        rsp_status_o,
    output logic [31:0]       rsp_paddr_o,
    output logic [3:0]        rsp_perm_o,
    output logic              mem_req_o,
    output logic [31:0]       mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam int unsigned HI_LSB  = OFF_W + IDX_W;

    typedef struct packed {
        walk_state_e        st;
        logic [ADDR_W-1:0]  va;
        logic [1:0]         kind;
        logic [ADDR_W-1:0]  base;
        logic [FRAME_W-1:0] frame;
        logic [1:0]         status;
        logic [ADDR_W-1:0]  paddr;
        logic [FLG_W-1:0]   perm;
    } walk_t;

    localparam walk_t WALK_RST = '{st: ST_IDLE, default: '0};

    walk_t walk_d, walk_q;

    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] entry_addr;
    logic              leaf_allow;
    logic              unused_rdata;

    assign unused_rdata = ^mem_rdata_i[OFF_W-1:FLG_DIRTY+1];

    assign sel_idx = (walk_q.st == ST_FETCH_L2) ? walk_q.va[HI_LSB-1:OFF_W]
                                                : walk_q.va[ADDR_W-1:HI_LSB];

    pgw_addr_gen #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .IDX_W    (IDX_W),
        .WORD_LOG2(WORD_LOG2)
    ) i_addr_gen (
        .use_frame_i(walk_q.st == ST_FETCH_L2),
        .base_i     (walk_q.base),
        .frame_i    (walk_q.frame),
        .idx_i      (sel_idx),
        .addr_o     (entry_addr)
    );

    pgw_perm_check i_perm_check (
        .flags_i(mem_rdata_i[FLG_DIRTY:FLG_READ]),
        .kind_i (walk_q.kind),
        .allow_o(leaf_allow)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    walk_d.st     = ST_FETCH_L1;
                    walk_d.va     = req_vaddr_i;
                    walk_d.kind   = req_kind_i;
                    walk_d.base   = tbl_base_i;
                    walk_d.status = RSP_OK;
                    walk_d.paddr  = '0;
                    walk_d.perm   = '0;
                end
            end
            ST_FETCH_L1: begin
                if (mem_rvalid_i) begin
                    if (!mem_rdata_i[FLG_VALID]) begin
                        walk_d.status = RSP_PAGE_FAULT;
                        walk_d.st     = ST_DONE;
                    end else begin
                        walk_d.frame = mem_rdata_i[ADDR_W-1:OFF_W];
                        walk_d.st    = ST_FETCH_L2;
                    end
                end
            end
            ST_FETCH_L2: begin
                if (mem_rvalid_i) begin
                    walk_d.st = ST_DONE;
                    if (!mem_rdata_i[FLG_VALID]) begin
                        walk_d.status = RSP_PAGE_FAULT;
                    end else if (!leaf_allow) begin
                        walk_d.status = RSP_PROT_FAULT;
                    end else begin
                        walk_d.status = RSP_OK;
                        walk_d.paddr  = {mem_rdata_i[ADDR_W-1:OFF_W], walk_q.va[OFF_W-1:0]};
                        walk_d.perm   = mem_rdata_i[FLG_DIRTY:FLG_READ];
                    end
                end
            end
            ST_DONE: begin
                if (rsp_ack_i) walk_d.st = ST_IDLE;
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= WALK_RST;
        else        walk_q <= walk_d;
    end

    assign req_ready_o  = (walk_q.st == ST_IDLE);
    assign rsp_valid_o  = (walk_q.st == ST_DONE);
    assign rsp_status_o = walk_q.status;
    assign rsp_paddr_o  = walk_q.paddr;
    assign rsp_perm_o   = walk_q.perm;
    assign mem_req_o    = (walk_q.st == ST_FETCH_L1) || (walk_q.st == ST_FETCH_L2);
    assign mem_addr_o   = entry_addr;

endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready_o,
    input logic        rsp_valid_o,
    input logic        rsp_ack_i,
    input logic [1:0]  rsp_status_o,
    input logic [31:0] rsp_paddr_o,
    input logic [3:0]  rsp_perm_o,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_rvalid_i
);
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!rsp_valid_o && !mem_req_o)); // R2

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ack_i) |=> (rsp_valid_o && $stable(rsp_status_o)
                                        && $stable(rsp_paddr_o) && $stable(rsp_perm_o))); // R9

    AST_ACK_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_ack_i) |=> req_ready_o); // R9

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10

    AST_NO_READ_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && rsp_valid_o)); // R10

    AST_FAULT_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_status_o != 2'd0) |-> (rsp_paddr_o == 32'd0 && rsp_perm_o == 4'd0)); // R11

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_status_o != 2'd3)); // R8
endmodule

bind pgw_walker pgw_walker_chk i_pgw_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ack_i   (rsp_ack_i),
    .rsp_status_o(rsp_status_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_perm_o  (rsp_perm_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/test_pgw_walker.sv
`timescale 1ns/1ps
module test_pgw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        rsp_valid_o;
    logic        rsp_ack_i = 1'b0;
    logic [1:0]  rsp_status_o;
    logic [31:0] rsp_paddr_o;
    logic [3:0]  rsp_perm_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          spur    = 1'b0;
    int unsigned log_n   = 0;
    logic [31:0] log_addr [16];
    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;

    pgw_walker i_pgw_walker (.*);

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'd0;
    endfunction

    function automatic logic [31:0] va_of(input int unsigned d, input int unsigned t, input int unsigned o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    // memory model: one read at a time, random latency; stray data on request
    initial begin
        int unsigned wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid_i) begin
                mem_rvalid_i = 1'b0;
            end else if (mem_req_o) begin
                if (wait_cnt == 0) begin
                    mem_rdata_i  = rd(mem_addr_o);
                    mem_rvalid_i = 1'b1;
                    log_addr[log_n % 16] = mem_addr_o;
                    log_n++;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end else if (spur) begin
                mem_rdata_i  = 32'hFFFF_FFFF;
                mem_rvalid_i = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                        input bit noise, input string tag);
        logic [31:0] a1, a2, e1, e2, x_pa;
        logic [1:0]  x_st;
        logic [3:0]  x_pm;
        int unsigned x_n;
        int unsigned start_n;
        bit          allow;
        int unsigned guard;
        int unsigned hold;
        // expected result
        a1 = tbl_base_i + {20'd0, va[31:22], 2'b00};
        e1 = rd(a1);
        a2 = '0; x_pa = '0; x_pm = '0;
        if (!e1[0]) begin
            x_st = 2'd1; x_n = 1;
        end else begin
            x_n = 2;
            a2 = {e1[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
            e2 = rd(a2);
            case (kind)
                2'd0: allow = e2[1];
                2'd1: allow = e2[2];
                2'd2: allow = e2[3];
                default: allow = 1'b0;
            endcase
            if (!e2[0]) x_st = 2'd1;
            else if (!allow) x_st = 2'd2;
            else begin
                x_st = 2'd0; x_pa = {e2[31:12], va[11:0]}; x_pm = e2[4:1];
            end
        end
        // drive request
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R2", {tag, " ready before request"}, {31'd0, req_ready_o}, 32'd1);
        start_n = log_n;
        req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind;
        @(negedge clk);
        if (noise) begin
            req_vaddr_i = $urandom; req_kind_i = 2'($urandom);
        end else begin
            req_valid_i = 1'b0;
        end
        guard = 0;
        while (!rsp_valid_o && guard < 60) begin
            if (noise)
                chk(req_ready_o == 1'b0, "R2", {tag, " ready during walk"}, {31'd0, req_ready_o}, 32'd0);
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid_o == 1'b1, "R9", {tag, " response arrives"}, {31'd0, rsp_valid_o}, 32'd1);
        chk(rsp_status_o == x_st, (x_st == 2'd2) ? "R8" : (x_n == 1 ? "R6" : "R7"),
            {tag, " status"}, {30'd0, rsp_status_o}, {30'd0, x_st});
        chk(rsp_paddr_o == x_pa, (x_st == 2'd0) ? "R5" : "R11", {tag, " paddr"}, rsp_paddr_o, x_pa);
        chk(rsp_perm_o == x_pm, (x_st == 2'd0) ? "R5" : "R11", {tag, " perm"}, {28'd0, rsp_perm_o}, {28'd0, x_pm});
        chk(log_n - start_n == x_n, (x_n == 1) ? "R6" : "R10", {tag, " read count"}, log_n - start_n, x_n);
        if (log_n - start_n >= 1)
            chk(log_addr[start_n % 16] == a1, "R3", {tag, " first read address"}, log_addr[start_n % 16], a1);
        if (x_n == 2 && log_n - start_n >= 2)
            chk(log_addr[(start_n + 1) % 16] == a2, "R4", {tag, " second read address"},
                log_addr[(start_n + 1) % 16], a2);
        hold = $urandom % 3;
        for (int i = 0; i < int'(hold); i++) begin
            @(negedge clk);
            chk(rsp_valid_o && rsp_paddr_o == x_pa && rsp_status_o == x_st, "R9",
                {tag, " response held"}, rsp_paddr_o, x_pa);
        end
        rsp_ack_i = 1'b1; req_valid_i = 1'b0;
        @(negedge clk);
        rsp_ack_i = 1'b0;
        chk(req_ready_o && !rsp_valid_o, "R9", {tag, " ready after ack"}, {31'd0, req_ready_o}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd2718);
        // directed tables, base A
        mem[32'h0010_0000 + 1023*4] = {20'h00300, 12'h001};
        mem[32'h0030_0000 + 1023*4] = {20'hABCDE, 12'h003};      // read-only
        mem[32'h0030_0000 + 5*4]    = {20'h12345, 12'h01F};      // all flags + dirty
        mem[32'h0030_0000 + 6*4]    = {20'h55555, 12'h00E};      // invalid leaf
        mem[32'h0010_0000 + 7*4]    = {20'h00400, 12'h01E};      // invalid directory
        // base B
        mem[32'h0020_0000]          = {20'h00310, 12'h001};
        mem[32'h0031_0000]          = {20'h0BEEF, 12'h00B};      // read + exec
        // random tables under base A
        for (int d = 16; d < 24; d++) begin
            mem[32'h0010_0000 + d*4] = {20'h00500 + 20'(d), 11'($urandom), (d != 20)};
            for (int t = 0; t < 16; t++)
                mem[{20'h00500 + 20'(d), 12'd0} + t*4] =
                    {20'($urandom), 7'($urandom), 4'($urandom), ($urandom % 5) != 0};
        end

        repeat (3) @(negedge clk);
        chk(req_ready_o == 1'b1, "R1", "reset ready", {31'd0, req_ready_o}, 32'd1);
        chk(rsp_valid_o == 1'b0, "R1", "reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
        chk(mem_req_o == 1'b0, "R1", "reset mem_req", {31'd0, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        tbl_base_i = 32'h0010_0000;

        walk(va_of(1023, 1023, 12'hFFF), 2'd0, 0, "R5 top indices load");
        walk(va_of(1023, 1023, 12'h123), 2'd1, 0, "R8 store to read-only");
        walk(va_of(1023, 1023, 12'h000), 2'd2, 0, "R8 fetch non-exec");
        walk(va_of(1023, 5, 12'h800), 2'd1, 0, "R8 store writable");
        walk(va_of(1023, 5, 12'h801), 2'd3, 0, "R8 reserved kind");
        walk(va_of(7, 0, 12'h010), 2'd0, 0, "R6 invalid directory");
        walk(va_of(0, 0, 12'h010), 2'd2, 0, "R6 empty directory");
        walk(va_of(1023, 6, 12'h444), 2'd0, 0, "R7 invalid leaf");
        walk(va_of(1023, 5, 12'h0AA), 2'd2, 1, "R2 requests during walk");

        // R10: stray read data while idle
        spur = 1'b1;
        repeat (4) @(negedge clk);
        chk(!mem_req_o && !rsp_valid_o && req_ready_o, "R10", "stray rvalid ignored",
            {30'd0, mem_req_o, rsp_valid_o}, 32'd0);
        spur = 1'b0;
        @(negedge clk);

        // R3: base change picks the new directory
        tbl_base_i = 32'h0020_0000;
        walk(va_of(0, 0, 12'h3C4), 2'd2, 0, "R3 new base");
        tbl_base_i = 32'h0010_0000;

        for (int i = 0; i < 80; i++) begin
            walk(va_of(16 + ($urandom % 8), $urandom % 20, $urandom % 4096),
                 2'($urandom), ($urandom % 4) == 0, "R5 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule